// File: doc/BRIEF.md
# Set Device Bits Frame Receiver

This host-side block watches a stream of received 32-bit words. A valid strobe qualifies each word, and start and end markers delimit each frame. The block picks out the two-word Set Device Bits frame. When such a frame arrives intact, the block does three things:

- It loads a new value into the shadow Error register.
- It merges new values into six bits of the shadow Status register. Busy (bit 7) and data-request (bit 3) are never touched by the frame.
- It retires every queued command whose tag bit is set in the frame's second word.

The frame can also raise an interrupt-pending flag. This happens only when the frame asks for it and the shadow busy and data-request bits are both clear.

Other parts of the host use three side paths:
- A tag-set port marks commands as outstanding.
- An acknowledge input clears the interrupt-pending flag.
- A busy/data-request write port maintains those two status bits, since this frame never writes them.

Any frame that has the wrong type, the wrong length or is cut short is dropped. A dropped frame changes no state and produces a one-cycle drop indication.

Top module: `devbits_rx`

## Requirements
- R1: A frame is applied only when all of the following hold: a word with `inSof` high has `inData[7:0]` = 8'hA1, and the next valid word carries `inEof` high and `inSof` low. All register outputs show the result one clock after that second word is accepted.
- R2: On an applied frame, `shadowError` takes first-word bits 31:24. First-word bits 23, 19, 15 and 13:8 have no effect.
- R3: On an applied frame, `shadowStatus[6:4]` takes first-word bits 22:20 and `shadowStatus[2:0]` takes first-word bits 18:16.
- R4: An applied frame never changes `shadowStatus[7]` (busy) or `shadowStatus[3]` (data-request). Only the write port (`bdWe`, `bdBusy`, `bdDrq`) changes those two bits.
- R5: An applied frame with first-word bit 14 set raises `irqPending` only if `shadowStatus[7]` and `shadowStatus[3]` were both 0 in the cycle the second word was accepted.
- R6: `irqPending` stays set until a cycle with `irqAck` high clears it. If an acknowledge coincides with an interrupt-raising frame, the flag stays set.
- R7: The second word is a completion mask. Every tag whose bit is 1 is cleared from `outstanding` in a single update. For one cycle, `completedPulse` shows exactly those tags that were outstanding and got cleared; otherwise it is zero.
- R8: `swSetTags` ORs tags into `outstanding`. If a tag is set and completed in the same cycle, the completion wins and the tag ends up clear.
- R9: Each of these frames leaves error, status, interrupt and outstanding state unchanged and pulses `dropPulse` for one cycle: a one-word frame, a first word of another type, a frame still running after its second word, or a frame restarted by a new `inSof` before it ended. Words outside a frame are ignored.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Word on `inData` is valid |
| inSof | input | 1 | Word is the first of a frame |
| inEof | input | 1 | Word is the last of a frame |
| inData | input | 32 | Received word |
| swSetTags | input | 32 | Tags to mark as outstanding this cycle |
| irqAck | input | 1 | Clears the interrupt-pending flag |
| bdWe | input | 1 | Writes the busy and data-request status bits |
| bdBusy | input | 1 | New busy bit value |
| bdDrq | input | 1 | New data-request bit value |
| shadowError | output | 8 | Shadow Error register |
| shadowStatus | output | 8 | Shadow Status register |
| outstanding | output | 32 | Outstanding queued command tags |
| completedPulse | output | 32 | Tags retired in the previous update |
| irqPending | output | 1 | Interrupt pending flag |
| dropPulse | output | 1 | A malformed or foreign frame was dropped |

## Verification
Two situations are hard to reach.

The first is a frame restarted mid-header. It needs a second start marker to arrive while a valid header is already held. The stimulus sends two back-to-back start words and then an end word, and checks two things: the drop pulse appears on the second start, and the second header, not the first, is applied.

The second is a collision at the register edges. This means a tag set meeting a completion of the same tag, or an acknowledge meeting an interrupt-raising frame. The stimulus drives the side inputs in the very cycle the end word is accepted.

// File: rtl/devbits_pkg.sv
package devbits_pkg;

  typedef struct packed {
    logic captureHdr;
    logic applyFrame;
  } strobes_t;

  typedef enum logic [1:0] {
    RX_IDLE     = 2'd0,
    RX_HAVE_HDR = 2'd1,
    RX_DRAIN    = 2'd2
  } rxState_e;

endpackage

// File: rtl/devbits_ctrl.sv
module devbits_ctrl
  import devbits_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [TYPE_W-1:0] typeField,
  output strobes_t          strobes,
  output logic              dropPulse
);

  rxState_e state, nextState;
  logic     dropNext;

  always_comb begin
    nextState = state;
    strobes   = '0;
    dropNext  = 1'b0;
    if (inValid) begin
      if (inSof) begin
        // A start while a header is held ends that frame early.
        if (state == RX_HAVE_HDR) dropNext = 1'b1;
        if (inEof) begin
          dropNext  = 1'b1;
          nextState = RX_IDLE;
        end else if (typeField == TYPE_CODE) begin
          strobes.captureHdr = 1'b1;
          nextState          = RX_HAVE_HDR;
        end else begin
          dropNext  = 1'b1;
          nextState = RX_DRAIN;
        end
      end else begin
        case (state)
          RX_HAVE_HDR: begin
            if (inEof) begin
              strobes.applyFrame = 1'b1;
              nextState          = RX_IDLE;
            end else begin
              dropNext  = 1'b1;
              nextState = RX_DRAIN;
            end
          end
          RX_DRAIN: if (inEof) nextState = RX_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      dropPulse <= 1'b0;
    end else begin
      state     <= nextState;
      dropPulse <= dropNext;
    end
  end

  // R1: an apply is only possible on a non-start word
  assert_apply_not_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.applyFrame |-> (inValid && !inSof && inEof));

  // R9: a dropped word never applies in the same cycle
  assert_drop_excl_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.applyFrame |=> !dropPulse);

endmodule

// File: rtl/devbits_dp.sv
module devbits_dp
  import devbits_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TAG_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobes_t             strobes,
  input  logic [DATA_W-1:0]    inData,
  input  logic [TAG_COUNT-1:0] swSetTags,
  input  logic                 irqAck,
  input  logic                 bdWe,
  input  logic                 bdBusy,
  input  logic                 bdDrq,
  output logic [7:0]           shadowError,
  output logic [7:0]           shadowStatus,
  output logic [TAG_COUNT-1:0] outstanding,
  output logic [TAG_COUNT-1:0] completedPulse,
  output logic                 irqPending
);

  localparam int ERR_LSB  = 24;
  localparam int HI_LSB   = 20;
  localparam int LO_LSB   = 16;
  localparam int IRQ_BIT  = 14;
  localparam int BSY_BIT  = 7;
  localparam int DRQ_BIT  = 3;

  logic [7:0] hdrErr;
  logic [2:0] hdrHi, hdrLo;
  logic       hdrIrq;
  logic       applyNow;

  assign applyNow = strobes.applyFrame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdrErr <= '0;
      hdrHi  <= '0;
      hdrLo  <= '0;
      hdrIrq <= 1'b0;
    end else if (strobes.captureHdr) begin
      hdrErr <= inData[ERR_LSB +: 8];
      hdrHi  <= inData[HI_LSB +: 3];
      hdrLo  <= inData[LO_LSB +: 3];
      hdrIrq <= inData[IRQ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowError  <= '0;
      shadowStatus <= '0;
    end else begin
      if (applyNow) begin
        shadowError       <= hdrErr;
        shadowStatus[6:4] <= hdrHi;
        shadowStatus[2:0] <= hdrLo;
      end
      if (bdWe) begin
        shadowStatus[BSY_BIT] <= bdBusy;
        shadowStatus[DRQ_BIT] <= bdDrq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqPending <= 1'b0;
    end else if (applyNow && hdrIrq && !shadowStatus[BSY_BIT] && !shadowStatus[DRQ_BIT]) begin
      irqPending <= 1'b1;
    end else if (irqAck) begin
      irqPending <= 1'b0;
    end
  end

  for (genvar g = 0; g < TAG_COUNT; g++) begin : gTag
    logic hitTag;
    assign hitTag = applyNow && inData[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        outstanding[g]    <= 1'b0;
        completedPulse[g] <= 1'b0;
      end else begin
        outstanding[g]    <= (outstanding[g] | swSetTags[g]) & ~hitTag;
        completedPulse[g] <= hitTag & outstanding[g];
      end
    end
  end

  // R4: a frame with no busy/drq write keeps both bits
  assert_bsy_drq_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (applyNow && !bdWe) |=> ($stable(shadowStatus[BSY_BIT]) && $stable(shadowStatus[DRQ_BIT])));

  // R5: a rising interrupt needs busy and drq clear the cycle before
  assert_irq_needs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPending) |-> $past(!shadowStatus[BSY_BIT] && !shadowStatus[DRQ_BIT]));

  // R6: an acknowledge with no apply clears the flag
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && !applyNow) |=> !irqPending);

  // R7: retired tags were outstanding and are now clear
  assert_retired_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((completedPulse & ~$past(outstanding)) == '0) && ((completedPulse & outstanding) == '0)));

  // R2: without an apply the error register holds
  assert_error_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !applyNow |=> $stable(shadowError));

endmodule

// File: rtl/devbits_rx.sv
module devbits_rx
  import devbits_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TAG_COUNT = 32,
  parameter int TYPE_W    = 8,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 8'hA1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic                 inEof,
  input  logic [DATA_W-1:0]    inData,
  input  logic [TAG_COUNT-1:0] swSetTags,
  input  logic                 irqAck,
  input  logic                 bdWe,
  input  logic                 bdBusy,
  input  logic                 bdDrq,
  output logic [7:0]           shadowError,
  output logic [7:0]           shadowStatus,
  output logic [TAG_COUNT-1:0] outstanding,
  output logic [TAG_COUNT-1:0] completedPulse,
  output logic                 irqPending,
  output logic                 dropPulse
);

  strobes_t strobes;

  devbits_ctrl #(.TYPE_W(TYPE_W), .TYPE_CODE(TYPE_CODE)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .inSof     (inSof),
    .inEof     (inEof),
    .typeField (inData[TYPE_W-1:0]),
    .strobes   (strobes),
    .dropPulse (dropPulse)
  );

  devbits_dp #(.DATA_W(DATA_W), .TAG_COUNT(TAG_COUNT)) uDp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .inData         (inData),
    .swSetTags      (swSetTags),
    .irqAck         (irqAck),
    .bdWe           (bdWe),
    .bdBusy         (bdBusy),
    .bdDrq          (bdDrq),
    .shadowError    (shadowError),
    .shadowStatus   (shadowStatus),
    .outstanding    (outstanding),
    .completedPulse (completedPulse),
    .irqPending     (irqPending)
  );

  // R9: a drop never coincides with retired tags
  assert_drop_no_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dropPulse |-> (completedPulse == '0));

endmodule

// File: tb/tb_devbits_rx.sv
module tb_devbits_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [31:0] inData = '0;
  logic [31:0] swSetTags = '0;
  logic        irqAck = 1'b0, bdWe = 1'b0, bdBusy = 1'b0, bdDrq = 1'b0;
  logic [7:0]  shadowError, shadowStatus;
  logic [31:0] outstanding, completedPulse;
  logic        irqPending, dropPulse;

  int errors = 0;
  int checks = 0;

  logic [7:0]  expErr = '0;
  logic [7:0]  expStat = '0;
  logic [31:0] expOut = '0;
  logic        expIrq = 1'b0;

  always #2 clk = ~clk;

  devbits_rx dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .swSetTags(swSetTags), .irqAck(irqAck), .bdWe(bdWe),
    .bdBusy(bdBusy), .bdDrq(bdDrq), .shadowError(shadowError),
    .shadowStatus(shadowStatus), .outstanding(outstanding),
    .completedPulse(completedPulse), .irqPending(irqPending), .dropPulse(dropPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHdr(input logic [7:0] err, input logic [2:0] hi,
                                        input logic [2:0] lo, input logic irqb,
                                        input logic [7:0] junk, input logic [7:0] typ);
    return {err, junk[0], hi, junk[1], lo, junk[2], irqb, junk[7:2], typ};
  endfunction

  // Drive one word at a negedge; return at the next negedge (after it was accepted).
  task automatic putWord(input logic sof, input logic eof, input logic [31:0] d);
    @(negedge clk);
    inValid = 1'b1; inSof = sof; inEof = eof; inData = d;
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; inData = '0;
    swSetTags = '0; irqAck = 1'b0; bdWe = 1'b0;
  endtask

  task automatic idleCycle();
    @(negedge clk);
    swSetTags = '0; irqAck = 1'b0; bdWe = 1'b0;
  endtask

  task automatic applyModel(input logic [31:0] h, input logic [31:0] comp);
    if (h[14] && !expStat[7] && !expStat[3]) expIrq = 1'b1;
    expErr = h[31:24];
    expStat[6:4] = h[22:20];
    expStat[2:0] = h[18:16];
    expOut = expOut & ~comp;
  endtask

  task automatic writeBd(input logic b, input logic d);
    @(negedge clk);
    bdWe = 1'b1; bdBusy = b; bdDrq = d;
    @(negedge clk);
    bdWe = 1'b0;
    expStat[7] = b; expStat[3] = d;
  endtask

  task automatic ackIrq();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    expIrq = 1'b0;
  endtask

  task automatic checkState(input string req);
    chk({req, " error"}, {24'd0, shadowError}, {24'd0, expErr});
    chk({req, " status"}, {24'd0, shadowStatus}, {24'd0, expStat});
    chk({req, " outstanding"}, outstanding, expOut);
    chk({req, " irq"}, {31'd0, irqPending}, {31'd0, expIrq});
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] h;
    logic [31:0] prevOut;
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 error", {24'd0, shadowError}, 32'd0);
    chk("R10 status", {24'd0, shadowStatus}, 32'd0);
    chk("R10 outstanding", outstanding, 32'd0);
    chk("R10 pulse", completedPulse, 32'd0);
    chk("R10 irq/drop", {30'd0, irqPending, dropPulse}, 32'd0);
    rst_n = 1'b1;
    idleCycle();

    // R1 R2 R3: sweep every error value, varied status fields and ignored bits
    for (int v = 0; v < 256; v++) begin
      h = mkHdr(v[7:0], v[2:0] ^ 3'd5, v[5:3], 1'b0, ~v[7:0], 8'hA1);
      putWord(1'b1, 1'b0, h);
      chk("R1 no apply after first word", {24'd0, shadowError}, {24'd0, expErr});
      putWord(1'b0, 1'b1, 32'd0);
      applyModel(h, 32'd0);
      chk("R2 error field", {24'd0, shadowError}, {24'd0, expErr});
      chk("R3 status merge", {24'd0, shadowStatus}, {24'd0, expStat});
    end

    // R4 R5 R6: all busy/drq/irq-bit combinations
    for (int k = 0; k < 8; k++) begin
      writeBd(k[0], k[1]);
      h = mkHdr(8'h3C + 8'(k), 3'd7, 3'd7, k[2], 8'h00, 8'hA1);
      putWord(1'b1, 1'b0, h);
      putWord(1'b0, 1'b1, 32'd0);
      applyModel(h, 32'd0);
      chk("R4 busy/drq kept", {24'd0, shadowStatus}, {24'd0, expStat});
      chk("R5 irq condition", {31'd0, irqPending}, {31'd0, expIrq});
      repeat (2) idleCycle();
      chk("R6 irq held", {31'd0, irqPending}, {31'd0, expIrq});
      ackIrq();
      chk("R6 ack clears", {31'd0, irqPending}, 32'd0);
    end
    writeBd(1'b0, 1'b0);
    chk("R4 write port", {24'd0, shadowStatus}, {24'd0, expStat});

    // R6: acknowledge coinciding with a raising frame
    h = mkHdr(8'h11, 3'd1, 3'd2, 1'b1, 8'h00, 8'hA1);
    putWord(1'b1, 1'b0, h);
    putWord(1'b0, 1'b1, 32'd0);
    applyModel(h, 32'd0);
    chk("R5 raise", {31'd0, irqPending}, 32'd1);
    putWord(1'b1, 1'b0, h);
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b0; inEof = 1'b1; inData = 32'd0; irqAck = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0; irqAck = 1'b0;
    chk("R6 ack with raising frame", {31'd0, irqPending}, 32'd1);
    ackIrq();
    chk("R6 ack alone", {31'd0, irqPending}, 32'd0);

    // R7: tag retirement sweep
    for (int t = 0; t < 32; t++) begin
      @(negedge clk);
      swSetTags = 32'hFFFF_FFFF;
      @(negedge clk);
      swSetTags = '0;
      expOut = 32'hFFFF_FFFF;
      chk("R8 set all tags", outstanding, expOut);
      h = mkHdr(8'h00, 3'd0, 3'd0, 1'b0, 8'h00, 8'hA1);
      putWord(1'b1, 1'b0, h);
      putWord(1'b0, 1'b1, (32'd1 << t) | (32'd1 << ((t + 5) % 32)));
      prevOut = expOut;
      applyModel(h, (32'd1 << t) | (32'd1 << ((t + 5) % 32)));
      chk("R7 outstanding after retire", outstanding, expOut);
      chk("R7 pulse", completedPulse, prevOut & ~expOut);
      idleCycle();
      chk("R7 pulse one cycle", completedPulse, 32'd0);
    end
    // R7: mask with tags not outstanding reports only real ones
    prevOut = expOut;
    putWord(1'b1, 1'b0, h);
    putWord(1'b0, 1'b1, 32'h0F0F_0F0F);
    applyModel(h, 32'h0F0F_0F0F);
    chk("R7 partial pulse", completedPulse, prevOut & 32'h0F0F_0F0F);
    chk("R7 partial outstanding", outstanding, expOut);
    ackIrq();

    // R8: set and complete the same tag in the same cycle
    expOut = outstanding;
    putWord(1'b1, 1'b0, h);
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b0; inEof = 1'b1; inData = 32'h0000_0018;
    swSetTags = 32'h0000_0018 | 32'h0000_0100;
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0; inData = '0; swSetTags = '0;
    prevOut = expOut;
    expOut = (expOut | 32'h0000_0118) & ~32'h0000_0018;
    chk("R8 completion wins", outstanding, expOut);
    chk("R8 pulse only prior tags", completedPulse, prevOut & 32'h0000_0018);

    // R9: dropped frames
    @(negedge clk);
    swSetTags = 32'hA5A5_0000;
    @(negedge clk);
    swSetTags = '0;
    expOut = expOut | 32'hA5A5_0000;
    h = mkHdr(8'hEE, 3'd6, 3'd6, 1'b1, 8'h00, 8'hA0);
    putWord(1'b1, 1'b0, h);
    chk("R9 wrong type drop", {31'd0, dropPulse}, 32'd1);
    putWord(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R9 drop one cycle", {31'd0, dropPulse}, 32'd0);
    checkState("R9 wrong type");
    h = mkHdr(8'hEE, 3'd6, 3'd6, 1'b1, 8'h00, 8'hA1);
    putWord(1'b1, 1'b1, h);
    chk("R9 single word drop", {31'd0, dropPulse}, 32'd1);
    checkState("R9 single word");
    putWord(1'b1, 1'b0, h);
    putWord(1'b0, 1'b0, 32'hFFFF_FFFF);
    chk("R9 long frame drop", {31'd0, dropPulse}, 32'd1);
    putWord(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R9 long frame tail", {31'd0, dropPulse}, 32'd0);
    checkState("R9 long frame");
    putWord(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R9 stray word", {31'd0, dropPulse}, 32'd0);
    checkState("R9 stray word");
    // restart: first header abandoned, second header applied
    putWord(1'b1, 1'b0, h);
    chk("R9 no drop yet", {31'd0, dropPulse}, 32'd0);
    h = mkHdr(8'h5A, 3'd3, 3'd4, 1'b0, 8'h00, 8'hA1);
    putWord(1'b1, 1'b0, h);
    chk("R9 restart drop", {31'd0, dropPulse}, 32'd1);
    checkState("R9 restart");
    putWord(1'b0, 1'b1, 32'h0000_0000);
    applyModel(h, 32'd0);
    checkState("R1 restarted frame applied");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule